// File: doc/BRIEF.md
# Clock Gap Monitor

This block raises a reset request when the monitored system clock stops. It runs from a separate reference clock that is always on. The monitored clock is brought into the reference domain through a short flop synchronizer, and its rising edges are found there. Each rising edge reloads a gap timer. If the timer counts a full timeout window and no new edge arrives while the block is enabled, the block emits a one-cycle reset request.

The timeout is 100 µs. It is given in reference cycles as `REF_HZ / 10000`, with the fraction dropped. The request goes out on its own output, so a reset controller can log it as a separate cause and keep it apart from the external reset pin.

The enable is a level that is synchronous to the reference clock. While it is low, the timer is held at its reloaded value and no request can fire. When it returns high, timing starts again from a fresh window.

Top module: `clk_gap_monitor`

## Requirements
- R1: While `ref_rst_n` is low and in the cycle after it goes high, `rst_req` is 0. The first timing window starts from reset release.
- R2: A monitored clock whose rising edges are at most LIMIT reference cycles apart never causes a request.
- R3: LIMIT equals `REF_HZ / 10000`, rounded down. A monitored rising edge is recognised two reference cycles after it is sampled, through two synchronizer flops. If the next recognised rising edge is more than LIMIT reference cycles later, `rst_req` goes high exactly LIMIT cycles after the last one.
- R4: A request is a single-cycle pulse. After it fires, no further request is made until the timer is re-armed, even if the monitored clock stays stopped.
- R5: A recognised rising edge of the monitored clock re-arms the timer and reloads a full window.
- R6: When `det_en` goes from 0 to 1, the timer reloads a full window. No request can fire within LIMIT cycles of that rise.
- R7: While `det_en` is 0, no request is made. A request can appear at the earliest in the cycle after a clock edge at which `det_en` is 1.
- R8: Falling edges of the monitored clock do not retrigger the timer. Only rising edges reload it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| ref_clk | input | 1 | Always-on reference clock |
| ref_rst_n | input | 1 | Active-low reset, synchronous to `ref_clk` |
| mon_clk | input | 1 | Monitored clock, asynchronous to `ref_clk` |
| det_en | input | 1 | Detector enable level, synchronous to `ref_clk` |
| rst_req | output | 1 | One-cycle reset request on a missing clock |

## Verification
The assertions assume that `det_en` changes only in step with `ref_clk`. They also assume that each level of `mon_clk` lasts at least one full reference cycle, so that every rising edge reaches the synchronizer output. The stimulus changes both inputs only on the falling edge of the reference clock, and it holds each monitored level for a whole number of reference cycles, never less than one. Random hold lengths run from one cycle to well past LIMIT, so gaps fall on both sides of the threshold. Directed phases place gaps exactly at LIMIT and at LIMIT+1.

// File: rtl/clk_gap_monitor.sv
module clk_gap_monitor #(
  parameter int unsigned REF_HZ      = 1_000_000,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic ref_clk,
  input  logic ref_rst_n,
  input  logic mon_clk,
  input  logic det_en,
  output logic rst_req
);
  localparam int unsigned LIMIT = REF_HZ / 10000;
  localparam int unsigned CW    = (LIMIT < 2) ? 1 : $clog2(LIMIT);

  logic [SYNC_STAGES:0] sync_q;
  logic [CW-1:0]        age;
  logic                 armed;
  logic                 mon_rise;
  logic                 expire;

  always_ff @(posedge ref_clk) begin
    if (!ref_rst_n) sync_q <= '0;
    else            sync_q <= {sync_q[SYNC_STAGES-1:0], mon_clk};
  end

  assign mon_rise = sync_q[SYNC_STAGES-1] & ~sync_q[SYNC_STAGES];
  assign expire   = det_en & armed & ~mon_rise & (age == CW'(LIMIT - 1));

  always_ff @(posedge ref_clk) begin
    if (!ref_rst_n) begin
      age     <= '0;
      armed   <= 1'b1;
      rst_req <= 1'b0;
    end else begin
      rst_req <= expire;
      if (!det_en || mon_rise) begin
        age   <= '0;
        armed <= 1'b1;
      end else if (expire) begin
        armed <= 1'b0;
      end else if (armed) begin
        age <= age + 1'b1;
      end
    end
  end
endmodule

// File: rtl/gap_monitor_checks.sv
module gap_monitor_checks #(
  parameter int unsigned LIMIT = 100,
  parameter int unsigned CW    = 7
) (
  input logic          ref_clk,
  input logic          ref_rst_n,
  input logic          det_en,
  input logic          mon_rise,
  input logic [CW-1:0] age,
  input logic          armed,
  input logic          rst_req
);
  logic [31:0] quiet;

  always_ff @(posedge ref_clk) begin
    if (!ref_rst_n || !det_en || mon_rise) quiet <= '0;
    else if (quiet <= LIMIT)               quiet <= quiet + 1;
  end

  AST_RESET_QUIET: assert property (@(posedge ref_clk) !ref_rst_n |=> !rst_req); // R1
  AST_FIRE_ON_TIME: assert property (@(posedge ref_clk) disable iff (!ref_rst_n)
    rst_req |-> quiet == LIMIT); // R3
  AST_SINGLE_PULSE: assert property (@(posedge ref_clk) disable iff (!ref_rst_n)
    rst_req |=> !rst_req); // R4
  AST_RISE_RELOADS: assert property (@(posedge ref_clk) disable iff (!ref_rst_n)
    mon_rise |=> (age == '0) && armed); // R5
  AST_ENABLE_RELOADS: assert property (@(posedge ref_clk) disable iff (!ref_rst_n)
    $rose(det_en) |=> !rst_req); // R6
  AST_OFF_SILENT: assert property (@(posedge ref_clk) disable iff (!ref_rst_n)
    !det_en |=> !rst_req); // R7
  AST_AGE_BOUND: assert property (@(posedge ref_clk) disable iff (!ref_rst_n)
    age <= CW'(LIMIT - 1)); // R3
endmodule

bind clk_gap_monitor gap_monitor_checks #(.LIMIT(LIMIT), .CW(CW)) u_checks (
  .ref_clk  (ref_clk),
  .ref_rst_n(ref_rst_n),
  .det_en   (det_en),
  .mon_rise (mon_rise),
  .age      (age),
  .armed    (armed),
  .rst_req  (rst_req)
);

// File: tb/test_clk_gap_monitor.sv
module test_clk_gap_monitor;
  localparam int CLK_PERIOD = 10;
  localparam int REF_HZ     = 1_000_000;

  function automatic int limit_of(input longint hz);
    return int'((hz * 100) / 1_000_000);
  endfunction

  localparam int LIM = limit_of(REF_HZ);

  logic ref_clk = 1'b0;
  logic ref_rst_n = 1'b0;
  logic mon_clk = 1'b0;
  logic det_en = 1'b0;
  logic rst_req;

  int n_cmp = 0;
  int n_bad = 0;
  int pulses = 0;
  bit done = 0;
  string tag = "R1";

  clk_gap_monitor #(.REF_HZ(REF_HZ)) i_clk_gap_monitor (
    .ref_clk(ref_clk), .ref_rst_n(ref_rst_n), .mon_clk(mon_clk),
    .det_en(det_en), .rst_req(rst_req)
  );

  always #(CLK_PERIOD/2) ref_clk = ~ref_clk;

  // Requirement-level model: two synchronizer flops, rising detect, window of LIM cycles
  logic m1 = 0, m2 = 0, m3 = 0, m_armed = 1, exp_req = 0;
  int   m_age = 0;

  always @(posedge ref_clk) begin
    logic rise;
    rise = m2 & ~m3;
    if (!ref_rst_n) begin
      m1 = 0; m2 = 0; m3 = 0; m_age = 0; m_armed = 1; exp_req = 0;
    end else begin
      exp_req = 0;
      if (!det_en || rise) begin
        m_age = 0; m_armed = 1;
      end else if (m_armed) begin
        if (m_age == LIM - 1) begin
          exp_req = 1; m_armed = 0;
        end else m_age++;
      end
      m3 = m2; m2 = m1; m1 = mon_clk;
    end
  end

  task automatic check(input string req, input logic act, input logic exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: rst_req actual %0b expected %0b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic check_int(input string req, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  always @(negedge ref_clk) begin
    if (!done) begin
      check(tag, rst_req, exp_req);
      if (rst_req === 1'b1) pulses++;
    end
  end

  task automatic step(input logic m, input logic e, input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge ref_clk);
      mon_clk = m;
      det_en  = e;
    end
  endtask

  task automatic finish_run;
    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    n_bad++;
    $display("FAIL watchdog: actual running expected finished");
    finish_run();
  end

  initial begin
    int p0;
    void'($urandom(32'h5eed_1234));
    check_int("R3", LIM, REF_HZ / 10000);
    tag = "R1";
    step(0, 0, 4);
    check("R1", rst_req, 1'b0);
    @(negedge ref_clk); ref_rst_n = 1'b1; det_en = 1'b1;
    check("R1", rst_req, 1'b0);
    p0 = pulses;
    step(0, 1, LIM + 3);
    check_int("R1", pulses - p0, 1);

    tag = "R2"; p0 = pulses;
    step(1, 1, 1);
    for (int k = 0; k < 30; k++) begin step(1, 1, 5); step(0, 1, 5); end
    for (int k = 0; k < 6; k++) begin step(1, 1, 1); step(0, 1, LIM - 1); end
    check_int("R2", pulses - p0, 0);

    tag = "R3"; p0 = pulses;
    for (int k = 0; k < 6; k++) begin step(1, 1, 1); step(0, 1, LIM); end
    step(1, 1, 1); step(0, 1, 3);
    check_int("R3", pulses - p0, 6);

    tag = "R4"; p0 = pulses;
    step(0, 1, 5 * LIM);
    check_int("R4", pulses - p0, 1);

    tag = "R5"; p0 = pulses;
    step(1, 1, 1); step(0, 1, 3 * LIM);
    check_int("R5", pulses - p0, 1);

    tag = "R8"; p0 = pulses;
    step(1, 1, 1); step(1, 1, 2 * LIM);
    check_int("R8", pulses - p0, 1);
    step(0, 1, 2 * LIM);
    check_int("R8", pulses - p0, 1);

    tag = "R6"; p0 = pulses;
    step(0, 0, 20);
    step(0, 1, LIM);
    check_int("R6", pulses - p0, 0);
    step(0, 1, 4);
    check_int("R6", pulses - p0, 1);

    tag = "R7"; p0 = pulses;
    step(0, 0, 5 * LIM);
    check_int("R7", pulses - p0, 0);

    tag = "R3";
    for (int k = 0; k < 3000; k++) begin
      logic e;
      int   hold;
      e = ($urandom_range(0, 9) != 0);
      hold = ($urandom_range(0, 3) == 0) ? $urandom_range(LIM - 5, LIM + 20)
                                          : $urandom_range(1, LIM / 2);
      step(~mon_clk, e, hold);
    end
    step(0, 1, 4);
    finish_run();
  end
endmodule